// File: doc/BRIEF.md
# Synchronous-Serial Absolute Angle Receiver

This block polls an absolute rotary encoder through a synchronous serial link. It generates the link clock itself and reads 17 bits on each transaction: a 16-bit angle, most significant bit first, and then one error bit. After the last bit it holds the clock high for a fixed idle gap, then starts the next read. Reads repeat without a pause in this pattern.

Each good read updates a 16-bit angle output. The upper 8 bits of the angle form a slice index, which gives 256 slices per turn. When a good read moves the slice index to a new value, the block sends out a single-cycle slice-change strobe. Downstream display logic uses this strobe to advance to the next slice.

A read that carries the error bit is dropped, and it sets an error output that stays high until reset. The defaults assume a 33 MHz system clock. Each half period of the serial clock is 8 system cycles, so the link runs at about 2 MHz. The idle gap is 660 system cycles, which is 20 µs. One transaction therefore takes 924 cycles, about 28 µs.

Top module: `ssi_angle_rx`

## Requirements
- R1: Out of reset the serial clock is high. Its first falling edge comes exactly GAP_CYC system cycles after reset is released.
- R2: Each transaction has exactly 17 serial clock pulses. Every low phase and every high phase lasts HALF_CYC system cycles.
- R3: After the 17th rising edge the serial clock stays high for exactly GAP_CYC system cycles, then falls to start the next transaction.
- R4: Data is sampled on the system edge that raises the serial clock. The first sampled bit is angle bit 15 and the sixteenth is angle bit 0. The seventeenth bit is the error flag, where 1 marks a bad read.
- R5: After a good read, the angle output takes the received value one system cycle after the 17th rising edge. The slice index output always equals angle[15:8].
- R6: The slice-change strobe is high for exactly one system cycle, one cycle after the 17th rising edge. It fires only when a good read gives a slice index that differs from the index of the last good read.
- R7: The first good read after reset always raises the slice-change strobe.
- R8: A read with the error flag set leaves the angle and the slice index unchanged and raises no strobe.
- R9: A bad read sets the error output. The error output then stays high until reset, even after later good reads.
- R10: During reset and until the first read completes, the serial clock is 1 and the angle, slice index, error output and strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ssi_data_i | input | 1 | Serial data from the encoder |
| ssi_clk_o | output | 1 | Serial clock to the encoder, idles high |
| angle_o | output | 16 | Last good angle received |
| slice_idx_o | output | 8 | Slice index, equal to angle_o[15:8] |
| read_err_o | output | 1 | Sticky flag, set by a read with the error bit |
| slice_sync_o | output | 1 | One-cycle strobe when the slice index changes |

## Verification
A wrong phase or counter value in the clock sequencer moves an edge of ssi_clk_o, and the cycle-exact model sees that on the same cycle. A bad bit counter or shift register gives a wrong angle, visible one cycle after the 17th rising edge of that transaction. A fault in the tracker shows up in three ways: a strobe that is missing, doubled or misplaced; an angle that changes after a bad read; or an error flag that clears. Each of these appears at the ports within one transaction, which is 924 cycles.

// File: rtl/ssi_rx_pkg.sv
package ssi_rx_pkg;
    typedef enum logic [1:0] {
        PH_GAP  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/ssi_clk_seq.sv
module ssi_clk_seq
    import ssi_rx_pkg::*;
#(
    parameter int HALF_CYC = 8,
    parameter int GAP_CYC  = 660,
    parameter int NBITS    = 17
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic shift_o,
    output logic last_o
);
    localparam int CNT_MAX = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int BW      = $clog2(NBITS + 1);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
        logic [BW-1:0]   bitn;
        logic            sclk;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        shift_o = 1'b0;
        last_o  = 1'b0;
        case (s_q.ph)
            PH_GAP: begin
                if (s_q.cnt == CW'(GAP_CYC - 1)) begin
                    s_d.ph   = PH_LOW;
                    s_d.cnt  = '0;
                    s_d.bitn = '0;
                    s_d.sclk = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_LOW: begin
                if (s_q.cnt == CW'(HALF_CYC - 1)) begin
                    shift_o  = 1'b1;
                    s_d.sclk = 1'b1;
                    s_d.cnt  = '0;
                    if (s_q.bitn == BW'(NBITS - 1)) begin
                        last_o = 1'b1;
                        s_d.ph = PH_GAP;
                    end else begin
                        s_d.ph = PH_HIGH;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (s_q.cnt == CW'(HALF_CYC - 1)) begin
                    s_d.ph   = PH_LOW;
                    s_d.cnt  = '0;
                    s_d.sclk = 1'b0;
                    s_d.bitn = s_q.bitn + 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.ph   = PH_GAP;
                s_d.cnt  = '0;
                s_d.sclk = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph   <= PH_GAP;
            s_q.cnt  <= '0;
            s_q.bitn <= '0;
            s_q.sclk <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.sclk;

    // R2: bit counter never runs past the frame length
    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bitn < BW'(NBITS));

    // R3: during the idle gap the serial clock is held high
    p_gap_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GAP) |-> sclk_o);

    // R2: a phase counter never exceeds its limit outside the gap
    p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_GAP) |-> (s_q.cnt < CW'(HALF_CYC)));
endmodule

// File: rtl/ssi_shift_in.sv
module ssi_shift_in #(
    parameter int NBITS = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata_i,
    input  logic             shift_i,
    input  logic             last_i,
    output logic [NBITS-1:0] word_o,
    output logic             vld_o
);
    typedef struct packed {
        logic [NBITS-1:0] sh;
        logic             vld;
    } shf_t;

    shf_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.vld = shift_i & last_i;
        if (shift_i) begin
            f_d.sh = {f_q.sh[NBITS-2:0], sdata_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.sh  <= '0;
            f_q.vld <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign word_o = f_q.sh;
    assign vld_o  = f_q.vld;

    // R4: a completed word is flagged only right after a shift
    p_vld_after_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && last_i) |=> vld_o);
endmodule

// File: rtl/ssi_slice_track.sv
module ssi_slice_track #(
    parameter int POS_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [POS_W:0]   word_i,
    output logic [POS_W-1:0] pos_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             err_o,
    output logic             sync_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             have;
        logic             err;
        logic             sync;
    } trk_t;

    trk_t t_d, t_q;
    logic [IDX_W-1:0] new_idx;

    assign new_idx = word_i[POS_W -: IDX_W];

    always_comb begin
        t_d      = t_q;
        t_d.sync = 1'b0;
        if (vld_i) begin
            if (word_i[0]) begin
                t_d.err = 1'b1;
            end else begin
                t_d.pos  = word_i[POS_W:1];
                t_d.have = 1'b1;
                t_d.sync = !t_q.have || (new_idx != t_q.pos[POS_W-1 -: IDX_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.pos  <= '0;
            t_q.have <= 1'b0;
            t_q.err  <= 1'b0;
            t_q.sync <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign pos_o  = t_q.pos;
    assign idx_o  = t_q.pos[POS_W-1 -: IDX_W];
    assign err_o  = t_q.err;
    assign sync_o = t_q.sync;

    // R6: the strobe never lasts two cycles
    p_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);

    // R6: a strobe is always caused by a word arriving the cycle before
    p_sync_from_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(vld_i));

    // R8: a flagged read leaves the angle untouched
    p_hold_on_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && word_i[0]) |=> ($stable(pos_o) && !sync_o));

    // R9: the error flag never clears outside reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: rtl/ssi_angle_rx.sv
module ssi_angle_rx #(
    parameter int HALF_CYC = 8,
    parameter int GAP_CYC  = 660,
    parameter int POS_W    = 16,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ssi_data_i,
    output logic             ssi_clk_o,
    output logic [POS_W-1:0] angle_o,
    output logic [IDX_W-1:0] slice_idx_o,
    output logic             read_err_o,
    output logic             slice_sync_o
);
    localparam int NBITS = POS_W + 1;

    logic             shift;
    logic             last;
    logic [NBITS-1:0] word;
    logic             word_vld;

    ssi_clk_seq #(
        .HALF_CYC (HALF_CYC),
        .GAP_CYC  (GAP_CYC),
        .NBITS    (NBITS)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_o  (ssi_clk_o),
        .shift_o (shift),
        .last_o  (last)
    );

    ssi_shift_in #(
        .NBITS (NBITS)
    ) shf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdata_i (ssi_data_i),
        .shift_i (shift),
        .last_i  (last),
        .word_o  (word),
        .vld_o   (word_vld)
    );

    ssi_slice_track #(
        .POS_W (POS_W),
        .IDX_W (IDX_W)
    ) trk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (word_vld),
        .word_i (word),
        .pos_o  (angle_o),
        .idx_o  (slice_idx_o),
        .err_o  (read_err_o),
        .sync_o (slice_sync_o)
    );

    // R4: every sample coincides with a rising edge of the serial clock
    p_shift_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> $rose(ssi_clk_o));

    // R5: the angle only moves right after a completed word
    p_angle_moves_after_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(angle_o));
endmodule

// File: tb/ssi_angle_rx_tb_top.sv
module ssi_angle_rx_tb_top;
    localparam int HALF = 8;
    localparam int GAP  = 660;
    localparam int P    = 33 * HALF + GAP;
    localparam int NF   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b1;
    logic        sclk;
    logic [15:0] angle;
    logic [7:0]  sidx;
    logic        rerr;
    logic        ssync;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] fr_pos [NF];
    logic        fr_err [NF];
    string       fr_tag [NF];
    logic        bitq [$];

    always #5 clk = ~clk;

    ssi_angle_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ssi_data_i   (sdata),
        .ssi_clk_o    (sclk),
        .angle_o      (angle),
        .slice_idx_o  (sidx),
        .read_err_o   (rerr),
        .slice_sync_o (ssync)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic setf(input int i, input logic [15:0] p, input logic e, input string tg);
        fr_pos[i] = p;
        fr_err[i] = e;
        fr_tag[i] = tg;
    endtask

    initial begin
        logic [15:0] e_pos;
        logic        e_err, e_sync, e_have, e_sclk, prev_sclk;
        string       cur_tag;
        int          u, v, n;

        setf(0,  16'h1234, 1'b0, "R7");
        setf(1,  16'h12FF, 1'b0, "R6");
        setf(2,  16'h1300, 1'b0, "R6");
        setf(3,  16'hABCD, 1'b1, "R8");
        setf(4,  16'hAB00, 1'b0, "R9");
        setf(5,  16'hFFFF, 1'b0, "R4");
        setf(6,  16'h0000, 1'b0, "R6");
        setf(7,  16'h0001, 1'b1, "R8");
        setf(8,  16'h00FE, 1'b0, "R5");
        setf(9,  16'h8000, 1'b0, "R4");
        setf(10, 16'h5555, 1'b0, "R4");
        setf(11, 16'hAAAA, 1'b0, "R4");
        for (int i = 0; i < NF; i++) begin
            for (int b = 15; b >= 0; b--) bitq.push_back(fr_pos[i][b]);
            bitq.push_back(fr_err[i]);
        end

        repeat (4) @(negedge clk);
        // R10: reset values
        cmp("R10", "sclk", int'(sclk), 1);
        cmp("R10", "angle", int'(angle), 0);
        cmp("R10", "index", int'(sidx), 0);
        cmp("R10", "error", int'(rerr), 0);
        cmp("R10", "sync", int'(ssync), 0);
        rst_n = 1'b1;

        e_pos = '0; e_err = 0; e_sync = 0; e_have = 0;
        cur_tag = "R10";
        prev_sclk = 1'b1;
        for (int t = 1; t <= NF * P + 6; t++) begin
            @(negedge clk);
            // reference serial clock (R1, R2, R3)
            u = t % P;
            if (u < GAP) e_sclk = 1'b1;
            else begin
                v = u - GAP;
                e_sclk = ((v / HALF) % 2) == 1;
            end
            // reference tracker (R5 to R9)
            e_sync = 1'b0;
            if (t > 1 && ((t - 1) % P) == 0) begin
                n = (t - 1) / P - 1;
                if (n < NF) begin
                    cur_tag = fr_tag[n];
                    if (fr_err[n]) e_err = 1'b1;
                    else begin
                        e_sync = !e_have || (fr_pos[n][15:8] != e_pos[15:8]);
                        e_pos  = fr_pos[n];
                        e_have = 1'b1;
                    end
                end
            end
            cmp(t < GAP ? "R1" : (u < GAP ? "R3" : "R2"), "sclk", int'(sclk), int'(e_sclk));
            cmp(cur_tag, "angle", int'(angle), int'(e_pos));
            cmp("R5", "index", int'(sidx), int'(e_pos[15:8]));
            cmp(cur_tag, "sync", int'(ssync), int'(e_sync));
            cmp("R9", "error", int'(rerr), int'(e_err));
            // encoder model: new bit after each falling edge
            if (prev_sclk && !sclk) begin
                if (bitq.size() > 0) sdata = bitq.pop_front();
                else sdata = 1'b1;
            end
            prev_sclk = sclk;
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (NF * P + 2000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule